// File: doc/BRIEF.md
# Eight-bit accumulator processor with ring-counter control

The block is a small stored-program processor built around one 8-bit accumulator. Program and data share a 32-word by 8-bit internal memory. Each instruction word carries a 3-bit operation code in its upper bits and a 5-bit direct address in its lower bits. A one-hot ring counter steps the machine through timing states. A hardwired decoder turns each timing state and the current operation into register load strobes on a single shared bus. The bus connects the program counter, the memory address and data registers, the instruction register, the accumulator, two spare registers and the arithmetic unit.

In use, the surrounding logic holds the core in synchronous reset and fills memory through a write port. It then releases reset and waits for the halt output. A monitor read port returns the memory word at the load-port address at any time, so results the program has stored can be read back. Besides the accumulator operations (load, store, add, AND, invert, shift left), the machine can move the accumulator into one of two spare registers, choosing which one from the carry flag.

Top module: `acc_cpu`

## Requirements
- R1: While `rst` is high at a clock edge, PC, ACC, P, Q and the carry flag go to 0, the zero flag goes to 1, `halted_o` goes to 0 and the timing ring restarts at its first state.
- R2: A write through the load port (`ld_we`, `ld_addr`, `ld_data`) takes effect only at an edge where `rst` is high, and is ignored while the core runs. `mon_data` always shows the memory word at `ld_addr`.
- R3: Instruction bits 7:5 hold the operation code and bits 4:0 the operand address. The codes are load 000, add 001, store 010, AND 011, invert 100, shift-left 101, carry-selected move 110 and halt 111.
- R4: The ring counter keeps exactly one state active. Fetch takes three states: address from PC, memory into the data register, then the word into the instruction register with its address field into the address register. The address register changes only in the first and third states. Load, add and AND take 5 cycles and the other instructions take 4.
- R5: PC advances by one, modulo 32, exactly once per instruction, in the second fetch state.
- R6: Load copies the addressed word into ACC. Store writes ACC to the addressed word.
- R7: Add sets ACC to (ACC + word) mod 256 and the carry flag to bit 8 of the sum.
- R8: AND and invert change ACC only and leave the carry flag unchanged.
- R9: Shift-left moves ACC up one bit, fills bit 0 with 0 and puts the old bit 7 into the carry flag.
- R10: After every cycle the zero flag is 1 exactly when ACC is zero.
- R11: The carry-selected move copies ACC into P when the carry flag is 1 and into Q when it is 0. The other spare register is left unchanged.
- R12: Halt raises `halted_o` at the end of its last state. From then until reset, PC, ACC, flags, P, Q and memory hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset; also opens the load port |
| ld_we | input | 1 | Load-port write strobe |
| ld_addr | input | 5 | Load-port and monitor address |
| ld_data | input | 8 | Load-port write data |
| mon_data | output | 8 | Memory word at `ld_addr` |
| pc_o | output | 5 | Program counter |
| acc_o | output | 8 | Accumulator |
| p_o | output | 8 | Spare register P |
| q_o | output | 8 | Spare register Q |
| cy_o | output | 1 | Carry flag |
| z_o | output | 1 | Zero flag |
| halted_o | output | 1 | Processor has executed halt |

## Verification
The properties assume that reset is held for at least one edge before the first run, so the ring and registers start from defined values. They also assume the load port is used only while reset is asserted. All eight operation codes are defined, so any memory content is a legal program. The stimulus still writes every program word and data word in reset and ends every program with halt. One run holds a write strobe active during execution, to show that the write has no effect, and nothing else drives the load port while the core runs.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;

    localparam int DW        = 8;
    localparam int AW        = 5;
    localparam int OPW       = 3;
    localparam int NT        = 5;
    localparam int MEM_DEPTH = 1 << AW;

    typedef logic [DW-1:0] word_t;
    typedef logic [AW-1:0] addr_t;

    typedef enum logic [OPW-1:0] {
        OP_LDA  = 3'd0,
        OP_ADD  = 3'd1,
        OP_STA  = 3'd2,
        OP_AND  = 3'd3,
        OP_NOT  = 3'd4,
        OP_SHL  = 3'd5,
        OP_MOVP = 3'd6,
        OP_HLT  = 3'd7
    } opcode_e;

    typedef enum logic [2:0] {
        ALU_PASS,
        ALU_ADD,
        ALU_AND,
        ALU_NOT,
        ALU_SHL
    } alu_op_e;

    typedef enum logic [2:0] {
        BUS_NONE,
        BUS_PC,
        BUS_MDR,
        BUS_ACC,
        BUS_ALU
    } bus_src_e;

    typedef struct packed {
        bus_src_e bus_src;
        alu_op_e  alu_op;
        logic     ld_mar;
        logic     ld_mdr;
        logic     pc_inc;
        logic     ld_ir;
        logic     mem_we;
        logic     ld_acc;
        logic     ld_cy;
        logic     ld_p;
        logic     ld_q;
        logic     set_halt;
        logic     last;
    } ctrl_t;

    typedef struct packed {
        word_t res;
        logic  cout;
    } alu_out_t;

    localparam ctrl_t CTRL_IDLE = '{
        bus_src: BUS_NONE, alu_op: ALU_PASS, ld_mar: 1'b0, ld_mdr: 1'b0,
        pc_inc: 1'b0, ld_ir: 1'b0, mem_we: 1'b0, ld_acc: 1'b0, ld_cy: 1'b0,
        ld_p: 1'b0, ld_q: 1'b0, set_halt: 1'b0, last: 1'b0
    };

    function automatic opcode_e op_field(word_t w);
        return opcode_e'(w[DW-1 -: OPW]);
    endfunction

    function automatic addr_t addr_field(word_t w);
        return w[AW-1:0];
    endfunction

    function automatic alu_out_t alu_eval(alu_op_e op, word_t a, word_t b, logic cin);
        alu_out_t       r;
        logic [DW:0]    sum;
        sum    = {1'b0, a} + {1'b0, b};
        r.res  = b;
        r.cout = cin;
        case (op)
            ALU_PASS: r.res = b;
            ALU_ADD:  begin r.res = sum[DW-1:0]; r.cout = sum[DW]; end
            ALU_AND:  r.res = a & b;
            ALU_NOT:  r.res = ~a;
            ALU_SHL:  begin r.res = {a[DW-2:0], 1'b0}; r.cout = a[DW-1]; end
            default:  r.res = b;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/acc_ring.sv
module acc_ring
    import acc_cpu_pkg::*;
#(
    parameter int STATES = NT
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              hold,
    input  logic              restart,
    output logic [STATES-1:0] tstate
);

    logic [STATES-1:0] rotated;
    localparam logic [STATES-1:0] FIRST = STATES'(1);

    generate
        if (STATES > 1) begin : g_rot
            assign rotated = {tstate[STATES-2:0], tstate[STATES-1]};
        end else begin : g_single
            assign rotated = tstate;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            tstate <= FIRST;
        end else if (hold) begin
            tstate <= tstate;
        end else if (restart) begin
            tstate <= FIRST;
        end else begin
            tstate <= rotated;
        end
    end

endmodule

// File: rtl/acc_ctrl.sv
module acc_ctrl
    import acc_cpu_pkg::*;
(
    input  logic [NT-1:0] tstate,
    input  word_t         ir,
    input  logic          cy,
    input  logic          halted,
    output ctrl_t         ctl
);

    opcode_e op;
    assign op = op_field(ir);

    always_comb begin
        ctl = CTRL_IDLE;
        if (!halted) begin
            if (tstate[0]) begin
                ctl.bus_src = BUS_PC;
                ctl.ld_mar  = 1'b1;
            end
            if (tstate[1]) begin
                ctl.ld_mdr = 1'b1;
                ctl.pc_inc = 1'b1;
            end
            if (tstate[2]) begin
                ctl.bus_src = BUS_MDR;
                ctl.ld_ir   = 1'b1;
                ctl.ld_mar  = 1'b1;
            end
            if (tstate[3]) begin
                case (op)
                    OP_LDA, OP_ADD, OP_AND: ctl.ld_mdr = 1'b1;
                    OP_STA: begin
                        ctl.bus_src = BUS_ACC;
                        ctl.mem_we  = 1'b1;
                        ctl.last    = 1'b1;
                    end
                    OP_NOT: begin
                        ctl.alu_op  = ALU_NOT;
                        ctl.bus_src = BUS_ALU;
                        ctl.ld_acc  = 1'b1;
                        ctl.last    = 1'b1;
                    end
                    OP_SHL: begin
                        ctl.alu_op  = ALU_SHL;
                        ctl.bus_src = BUS_ALU;
                        ctl.ld_acc  = 1'b1;
                        ctl.ld_cy   = 1'b1;
                        ctl.last    = 1'b1;
                    end
                    OP_MOVP: begin
                        ctl.bus_src = BUS_ACC;
                        ctl.ld_p    = cy;
                        ctl.ld_q    = ~cy;
                        ctl.last    = 1'b1;
                    end
                    default: begin
                        ctl.set_halt = 1'b1;
                        ctl.last     = 1'b1;
                    end
                endcase
            end
            if (tstate[4]) begin
                ctl.bus_src = BUS_ALU;
                ctl.last    = 1'b1;
                case (op)
                    OP_LDA: begin
                        ctl.alu_op = ALU_PASS;
                        ctl.ld_acc = 1'b1;
                    end
                    OP_ADD: begin
                        ctl.alu_op = ALU_ADD;
                        ctl.ld_acc = 1'b1;
                        ctl.ld_cy  = 1'b1;
                    end
                    OP_AND: begin
                        ctl.alu_op = ALU_AND;
                        ctl.ld_acc = 1'b1;
                    end
                    default: ctl.bus_src = BUS_NONE;
                endcase
            end
        end
    end

endmodule

// File: rtl/acc_mem.sv
module acc_mem
    import acc_cpu_pkg::*;
#(
    parameter int DEPTH = MEM_DEPTH
) (
    input  logic  clk,
    input  logic  we,
    input  addr_t waddr,
    input  word_t wdata,
    input  addr_t raddr,
    output word_t rdata,
    input  addr_t maddr,
    output word_t mdata
);

    word_t store [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            store[waddr] <= wdata;
        end
    end

    assign rdata = store[raddr];
    assign mdata = store[maddr];

endmodule

// File: rtl/acc_dpath.sv
module acc_dpath
    import acc_cpu_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  ctrl_t ctl,
    input  word_t mem_rdata,
    output word_t bus,
    output addr_t pc,
    output addr_t mar,
    output word_t mdr,
    output word_t ir,
    output word_t acc,
    output word_t p,
    output word_t q,
    output logic  cy,
    output logic  z,
    output logic  halted
);

    alu_out_t alu;

    assign alu = alu_eval(ctl.alu_op, acc, mdr, cy);

    always_comb begin
        case (ctl.bus_src)
            BUS_PC:  bus = {{(DW-AW){1'b0}}, pc};
            BUS_MDR: bus = mdr;
            BUS_ACC: bus = acc;
            BUS_ALU: bus = alu.res;
            default: bus = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pc     <= '0;
            mar    <= '0;
            mdr    <= '0;
            ir     <= '0;
            acc    <= '0;
            p      <= '0;
            q      <= '0;
            cy     <= 1'b0;
            z      <= 1'b1;
            halted <= 1'b0;
        end else begin
            if (ctl.pc_inc)   pc     <= pc + addr_t'(1);
            if (ctl.ld_mar)   mar    <= addr_field(bus);
            if (ctl.ld_mdr)   mdr    <= mem_rdata;
            if (ctl.ld_ir)    ir     <= bus;
            if (ctl.ld_acc) begin
                acc <= bus;
                z   <= (bus == '0);
            end
            if (ctl.ld_cy)    cy     <= alu.cout;
            if (ctl.ld_p)     p      <= bus;
            if (ctl.ld_q)     q      <= bus;
            if (ctl.set_halt) halted <= 1'b1;
        end
    end

endmodule

// File: rtl/acc_cpu.sv
module acc_cpu
    import acc_cpu_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          ld_we,
    input  logic [AW-1:0] ld_addr,
    input  logic [DW-1:0] ld_data,
    output logic [DW-1:0] mon_data,
    output logic [AW-1:0] pc_o,
    output logic [DW-1:0] acc_o,
    output logic [DW-1:0] p_o,
    output logic [DW-1:0] q_o,
    output logic          cy_o,
    output logic          z_o,
    output logic          halted_o
);

    logic [NT-1:0] tstate;
    ctrl_t         ctl;
    word_t         bus;
    word_t         mem_rdata;
    addr_t         mar;
    word_t         mdr;
    word_t         ir;
    logic          mem_we;
    addr_t         mem_waddr;
    word_t         mem_wdata;

    assign mem_we    = rst ? ld_we   : ctl.mem_we;
    assign mem_waddr = rst ? ld_addr : mar;
    assign mem_wdata = rst ? ld_data : bus;

    acc_ring #(.STATES(NT)) ring_i (
        .clk     (clk),
        .rst     (rst),
        .hold    (halted_o),
        .restart (ctl.last),
        .tstate  (tstate)
    );

    acc_ctrl ctrl_i (
        .tstate (tstate),
        .ir     (ir),
        .cy     (cy_o),
        .halted (halted_o),
        .ctl    (ctl)
    );

    acc_mem #(.DEPTH(MEM_DEPTH)) mem_i (
        .clk   (clk),
        .we    (mem_we),
        .waddr (mem_waddr),
        .wdata (mem_wdata),
        .raddr (mar),
        .rdata (mem_rdata),
        .maddr (ld_addr),
        .mdata (mon_data)
    );

    acc_dpath dpath_i (
        .clk       (clk),
        .rst       (rst),
        .ctl       (ctl),
        .mem_rdata (mem_rdata),
        .bus       (bus),
        .pc        (pc_o),
        .mar       (mar),
        .mdr       (mdr),
        .ir        (ir),
        .acc       (acc_o),
        .p         (p_o),
        .q         (q_o),
        .cy        (cy_o),
        .z         (z_o),
        .halted    (halted_o)
    );

endmodule

// File: rtl/acc_cpu_chk.sv
module acc_cpu_chk
    import acc_cpu_pkg::*;
(
    input logic          clk,
    input logic          rst,
    input logic [NT-1:0] tstate,
    input addr_t         mar,
    input word_t         ir,
    input addr_t         pc,
    input word_t         acc,
    input word_t         p,
    input word_t         q,
    input logic          cy,
    input logic          z,
    input logic          halted
);

    logic is_movp;
    logic is_shl;
    assign is_movp = (ir[DW-1 -: OPW] == OP_MOVP);
    assign is_shl  = (ir[DW-1 -: OPW] == OP_SHL);

    assert_ring_onehot_R4: assert property (@(posedge clk) disable iff (rst)
        $countones(tstate) == 1);

    assert_mar_window_R4: assert property (@(posedge clk) disable iff (rst)
        (!tstate[0] && !tstate[2]) |=> $stable(mar));

    assert_pc_step_R5: assert property (@(posedge clk) disable iff (rst)
        !tstate[1] |=> $stable(pc));

    assert_zero_track_R10: assert property (@(posedge clk) disable iff (rst)
        z == (acc == '0));

    assert_carry_move_R11: assert property (@(posedge clk) disable iff (rst)
        (tstate[3] && is_movp && cy && !halted) |=> (p == $past(acc)) && $stable(q));

    assert_shift_left_R9: assert property (@(posedge clk) disable iff (rst)
        (tstate[3] && is_shl && !halted) |=>
            (acc == {$past(acc[DW-2:0]), 1'b0}) && (cy == $past(acc[DW-1])));

    assert_halt_freeze_R12: assert property (@(posedge clk) disable iff (rst)
        halted |=> halted && $stable(pc) && $stable(acc) && $stable(p)
                   && $stable(q) && $stable(cy));

endmodule

bind acc_cpu acc_cpu_chk chk_i (
    .clk    (clk),
    .rst    (rst),
    .tstate (tstate),
    .mar    (mar),
    .ir     (ir),
    .pc     (pc_o),
    .acc    (acc_o),
    .p      (p_o),
    .q      (q_o),
    .cy     (cy_o),
    .z      (z_o),
    .halted (halted_o)
);

// File: tb/acc_cpu_tb_top.sv
module acc_cpu_tb_top;

    logic       clk = 1'b0;
    logic       rst;
    logic       ld_we;
    logic [4:0] ld_addr;
    logic [7:0] ld_data;
    logic [7:0] mon_data;
    logic [4:0] pc_o;
    logic [7:0] acc_o, p_o, q_o;
    logic       cy_o, z_o, halted_o;

    always #5 clk = ~clk;

    acc_cpu dut_i (
        .clk(clk), .rst(rst), .ld_we(ld_we), .ld_addr(ld_addr), .ld_data(ld_data),
        .mon_data(mon_data), .pc_o(pc_o), .acc_o(acc_o), .p_o(p_o), .q_o(q_o),
        .cy_o(cy_o), .z_o(z_o), .halted_o(halted_o)
    );

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    // behavioural reference model
    logic [7:0] m_mem [32];
    logic [7:0] m_acc, m_p, m_q, m_ir;
    logic [4:0] m_pc, m_fa;
    logic       m_cy, m_z, m_halt;
    int         m_t;

    task automatic check(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] ins(int op, int a);
        return {op[2:0], a[4:0]};
    endfunction

    task automatic model_step();
        logic [4:0] a;
        logic [8:0] s;
        a = m_ir[4:0];
        case (m_t)
            0: begin m_fa = m_pc; m_t = 1; end
            1: begin m_pc = m_pc + 5'd1; m_t = 2; end
            2: begin m_ir = m_mem[m_fa]; m_t = 3; end
            3: begin
                m_t = 0;
                case (m_ir[7:5])
                    3'd0, 3'd1, 3'd3: m_t = 4;
                    3'd2: m_mem[a] = m_acc;
                    3'd4: m_acc = ~m_acc;
                    3'd5: begin m_cy = m_acc[7]; m_acc = m_acc << 1; end
                    3'd6: if (m_cy) m_p = m_acc; else m_q = m_acc;
                    default: m_halt = 1;
                endcase
            end
            default: begin
                m_t = 0;
                case (m_ir[7:5])
                    3'd0: m_acc = m_mem[a];
                    3'd1: begin s = m_acc + m_mem[a]; m_acc = s[7:0]; m_cy = s[8]; end
                    default: m_acc = m_acc & m_mem[a];
                endcase
            end
        endcase
        m_z = (m_acc == 8'h00);
    endtask

    always @(posedge clk) begin
        if (rst) begin
            m_pc = 0; m_acc = 0; m_p = 0; m_q = 0; m_ir = 0;
            m_cy = 0; m_z = 1; m_halt = 0; m_t = 0; m_fa = 0;
        end else if (!m_halt) begin
            model_step();
        end
    end

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (!rst && !done) begin
            check("R5 pc", pc_o, m_pc);
            check("R6 acc", acc_o, m_acc);
            check("R7 carry", cy_o, m_cy);
            check("R10 zero", z_o, m_z);
            check("R11 p", p_o, m_p);
            check("R11 q", q_o, m_q);
            check("R12 halted", halted_o, m_halt);
        end
    end

    task automatic load_word(int a, int d);
        @(negedge clk);
        ld_we = 1; ld_addr = a[4:0]; ld_data = d[7:0];
        m_mem[a] = d[7:0];
        @(negedge clk);
        ld_we = 0;
    endtask

    task automatic enter_reset();
        @(negedge clk);
        rst = 1;
        for (int i = 0; i < 32; i++) load_word(i, 0);
    endtask

    task automatic run_to_halt(output int cyc);
        @(negedge clk);
        rst = 0;
        cyc = 0;
        while (!halted_o && cyc < 2000) begin
            @(negedge clk);
            cyc++;
        end
        if (cyc >= 2000) check("R12 run timeout", 0, 1);
        repeat (6) @(negedge clk);
    endtask

    task automatic peek(string tag, int a, int exp);
        ld_addr = a[4:0];
        #1;
        check(tag, mon_data, exp);
    endtask

    initial begin
        #2000000;
        n_fail++;
        $display("FAIL watchdog expired");
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        int cyc;
        rst = 1; ld_we = 0; ld_addr = 0; ld_data = 0;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 pc", pc_o, 0);
        check("R1 acc", acc_o, 0);
        check("R1 p", p_o, 0);
        check("R1 q", q_o, 0);
        check("R1 carry", cy_o, 0);
        check("R1 zero", z_o, 1);
        check("R1 halted", halted_o, 0);

        // program 1: (a+b)*5
        enter_reset();
        load_word(0, ins(0, 20)); load_word(1, ins(1, 21));
        load_word(2, ins(2, 22)); load_word(3, ins(5, 0));
        load_word(4, ins(5, 0));  load_word(5, ins(1, 22));
        load_word(6, ins(2, 22)); load_word(7, ins(7, 0));
        load_word(20, 5); load_word(21, 8);
        peek("R2 load readback", 21, 8);
        @(negedge clk);
        rst = 0;
        ld_we = 1; ld_addr = 30; ld_data = 8'hAA;
        cyc = 0;
        while (!halted_o && cyc < 2000) begin
            @(negedge clk);
            cyc++;
        end
        ld_we = 0;
        check("R4 cycles to halt", cyc, 35);
        repeat (6) @(negedge clk);
        peek("R2 run write ignored", 30, 0);
        peek("R6 stored product", 22, 65);
        check("R9 acc after program", acc_o, 65);
        check("R12 pc frozen", pc_o, 8);

        // program 2: xor from AND and NOT
        enter_reset();
        load_word(0, ins(0, 20));  load_word(1, ins(4, 0));
        load_word(2, ins(3, 21));  load_word(3, ins(4, 0));
        load_word(4, ins(2, 22));  load_word(5, ins(0, 21));
        load_word(6, ins(4, 0));   load_word(7, ins(3, 20));
        load_word(8, ins(4, 0));   load_word(9, ins(3, 22));
        load_word(10, ins(4, 0));  load_word(11, ins(2, 22));
        load_word(12, ins(7, 0));
        load_word(20, 8'hF2); load_word(21, 8'hD6);
        run_to_halt(cyc);
        peek("R8 xor result", 22, 8'h24);
        check("R8 carry untouched", cy_o, 0);
        check("R12 pc frozen", pc_o, 13);

        // program 3: carry-selected moves, shift-out to zero
        enter_reset();
        load_word(0, ins(0, 20)); load_word(1, ins(1, 21));
        load_word(2, ins(6, 0));  load_word(3, ins(1, 22));
        load_word(4, ins(6, 0));  load_word(5, ins(0, 23));
        load_word(6, ins(5, 0));  load_word(7, ins(7, 0));
        load_word(20, 8'hC8); load_word(21, 8'h50);
        load_word(22, 8'h01); load_word(23, 8'h80);
        run_to_halt(cyc);
        check("R3 R7 R11 p got wrapped sum", p_o, 8'h18);
        check("R11 q got sum", q_o, 8'h19);
        check("R9 acc shifted out", acc_o, 0);
        check("R9 carry from bit7", cy_o, 1);
        check("R10 zero set", z_o, 1);
        check("R12 halted", halted_o, 1);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule